// File: doc/BRIEF.md
# Multi-Lane Link Start-up Sequencer

This block sits on the transmit side of a multi-lane serial converter link. It runs the handshake that brings the link up. It decides, for every lane and on every frame clock, whether the lane sends comma characters, alignment characters or user data. It does not do any 8b/10b coding. One clock cycle is one frame clock, and each lane emits one octet per cycle. Each octet comes with a flag that marks it as a control character.

The receiver asks for synchronization by pulling an active-low request line low. While that line is low, every lane sends commas. When the receiver releases the line, the sequencer waits for the next local multiframe boundary. It then sends a four-multiframe alignment sequence, whose second multiframe carries a small block of link configuration octets, and after that it passes user data through. A local multiframe counter divides the frame clock by a selectable K. A rising edge on SYSREF sets that counter back to zero, so several transmitters share the same boundaries. If the request line drops for two frames in a row during alignment or data, the link falls back to commas. A drop of one frame only is ignored.

Top module: `link_sync_seq`

## Requirements
- R1: After reset, and for as long as the link state is comma (code 0), every lane outputs octet 0xBC with its control flag set to 1.
- R2: In the comma state, sync_n low keeps the state at comma. sync_n high moves the link to the wait state (code 1) on the next cycle, and the lanes keep sending 0xBC.
- R3: In the wait state, the alignment state (code 2) starts on the first cycle whose multiframe count is 0. If sync_n is low in the wait state, the link returns to comma on the next cycle, and this takes priority over a boundary.
- R4: The frames per multiframe are K = 4*(k_sel+1), which gives 4 to 32. The multiframe count runs 0 to K-1 and then wraps to 0. In every alignment multiframe, position K-1 carries 0x7C with the control flag set.
- R5: A rising edge on sysref (high now, low on the cycle before) makes the multiframe count 0 on the next cycle. A level held high causes no further reset. A rising edge seen in the wait state therefore starts alignment on the next cycle.
- R6: Alignment lasts exactly four multiframes. Position 0 of each multiframe carries 0x1C with the control flag set. Every position that is not a control character and not a configuration octet carries its own position number as data, with the flag cleared.
- R7: In the second alignment multiframe, position 1 carries 0x9C with the control flag set. Positions 2 to 5 carry configuration data with the flag cleared: the lane index, LANES-1, K-1, and then the 8-bit sum of those three. The start and end characters take precedence over these positions.
- R8: The data state (code 3) begins on the cycle after the last octet of the fourth multiframe. In the data state each lane outputs its byte of data_in from the previous cycle, with the control flag cleared.
- R9: In the alignment or data state, sync_n low on two consecutive cycles returns the link to comma on the cycle after the second low. A single low cycle leaves the state unchanged.
- R10: All lanes change phase on the same cycle. link_state encodes the phase as 0 for comma, 1 for wait, 2 for alignment and 3 for data, and the data state is entered only from the alignment state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n | input | 1 | Synchronization request from the receiver, active low |
| sysref | input | 1 | Multiframe phase reference; acts on its rising edge |
| k_sel | input | 3 | Selects the frames per multiframe, K = 4*(k_sel+1) |
| data_in | input | LANES*8 | User octets, lane n in bits [8n+7:8n] |
| lane_oct | output | LANES*8 | Octets sent on each lane, lane n in bits [8n+7:8n] |
| lane_ctl | output | LANES | Per-lane flag set when the octet is a control character |
| link_state | output | 2 | Current phase: 0 comma, 1 wait, 2 alignment, 3 data |

## Verification
The sequencer is brought up with three multiframe lengths: K=8 with free-running boundaries, K=32 with a SYSREF edge placed inside the wait state, and K=4. K=4 is where the start and end characters overlap the configuration positions, which shows whether the priority between them is right. Drops of sync_n are tried as a single-cycle low and as a two-cycle low in the data state, and as a low inside the wait state. These tell apart a correct two-frame filter from one that reacts to every low or never reacts. A SYSREF level held high through data and restart separates edge detection from level sensitivity. A reference model compares every lane octet, every control flag and the link state on every cycle.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

    typedef enum logic [1:0] {
        PH_COMMA = 2'd0,
        PH_WAIT  = 2'd1,
        PH_ALIGN = 2'd2,
        PH_DATA  = 2'd3
    } phase_e;

    localparam logic [7:0] CH_COMMA    = 8'hBC;
    localparam logic [7:0] CH_MF_START = 8'h1C;
    localparam logic [7:0] CH_MF_END   = 8'h7C;
    localparam logic [7:0] CH_CFG_MARK = 8'h9C;

    localparam int ALIGN_MFS   = 4;
    localparam int CFG_OCTETS  = 4;
    localparam int CFG_FIRST   = 2;

endpackage

// File: rtl/lmfc_counter.sv
module lmfc_counter
    import link_seq_pkg::*;
#(
    parameter int KSEL_W = 3,
    parameter int K_STEP = 4,
    parameter int CNT_W  = $clog2(K_STEP << KSEL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sysref,
    input  logic [KSEL_W-1:0] k_sel,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  k_last,
    output logic              wrap_next
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sref;
    } lmfc_st_t;

    lmfc_st_t st_d, st_q;
    logic     sref_rise;

    always_comb begin
        k_last    = CNT_W'((K_STEP * (32'(k_sel) + 32'd1)) - 32'd1);
        sref_rise = sysref & ~st_q.sref;
        st_d      = st_q;
        st_d.sref = sysref;
        if (sref_rise) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= k_last) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        wrap_next = (st_d.cnt == '0);
        cnt       = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/link_phase_fsm.sv
module link_phase_fsm
    import link_seq_pkg::*;
#(
    parameter int MF_W = $clog2(ALIGN_MFS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_n,
    input  logic            wrap_next,
    output phase_e          phase,
    output logic [MF_W-1:0] mf_idx
);

    localparam logic [MF_W-1:0] MF_LAST = MF_W'(ALIGN_MFS - 1);

    typedef struct packed {
        phase_e          phase;
        logic [MF_W-1:0] mf;
        logic            low;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    drop;

    always_comb begin
        st_d     = st_q;
        st_d.low = 1'b0;
        drop     = 1'b0;
        unique case (st_q.phase)
            PH_COMMA: begin
                if (sync_n) begin
                    st_d.phase = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (!sync_n) begin
                    st_d.phase = PH_COMMA;
                end else if (wrap_next) begin
                    st_d.phase = PH_ALIGN;
                    st_d.mf    = '0;
                end
            end
            PH_ALIGN, PH_DATA: begin
                st_d.low = ~sync_n;
                drop     = ~sync_n & st_q.low;
                if (drop) begin
                    st_d.phase = PH_COMMA;
                    st_d.low   = 1'b0;
                end else if (st_q.phase == PH_ALIGN && wrap_next) begin
                    if (st_q.mf == MF_LAST) begin
                        st_d.phase = PH_DATA;
                    end else begin
                        st_d.mf = st_q.mf + MF_W'(1);
                    end
                end
            end
            default: st_d.phase = PH_COMMA;
        endcase
        phase  = st_q.phase;
        mf_idx = st_q.mf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_COMMA;
            st_q.mf    <= '0;
            st_q.low   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lane_octet_mux.sv
module lane_octet_mux
    import link_seq_pkg::*;
#(
    parameter int LANE_ID = 0,
    parameter int LANES   = 4,
    parameter int CNT_W   = 5,
    parameter int MF_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase,
    input  logic [MF_W-1:0]  mf_idx,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] k_last,
    input  logic [7:0]       data_in,
    output logic [7:0]       oct,
    output logic             ctl
);

    localparam logic [7:0] CFG_ID    = 8'(LANE_ID);
    localparam logic [7:0] CFG_LANES = 8'(LANES - 1);

    logic [7:0] data_d, data_q;
    logic [7:0] cfg_k;
    logic [7:0] cfg_sum;
    logic       second_mf;

    always_comb begin
        data_d    = data_in;
        cfg_k     = 8'(k_last);
        cfg_sum   = CFG_ID + CFG_LANES + cfg_k;
        second_mf = (mf_idx == MF_W'(1));
        oct       = CH_COMMA;
        ctl       = 1'b1;
        unique case (phase)
            PH_COMMA, PH_WAIT: begin
                oct = CH_COMMA;
                ctl = 1'b1;
            end
            PH_ALIGN: begin
                if (cnt == '0) begin
                    oct = CH_MF_START;
                    ctl = 1'b1;
                end else if (cnt == k_last) begin
                    oct = CH_MF_END;
                    ctl = 1'b1;
                end else if (second_mf && cnt == CNT_W'(1)) begin
                    oct = CH_CFG_MARK;
                    ctl = 1'b1;
                end else if (second_mf && cnt == CNT_W'(CFG_FIRST)) begin
                    oct = CFG_ID;
                    ctl = 1'b0;
                end else if (second_mf && cnt == CNT_W'(CFG_FIRST + 1)) begin
                    oct = CFG_LANES;
                    ctl = 1'b0;
                end else if (second_mf && cnt == CNT_W'(CFG_FIRST + 2)) begin
                    oct = cfg_k;
                    ctl = 1'b0;
                end else if (second_mf && cnt == CNT_W'(CFG_FIRST + CFG_OCTETS - 1)) begin
                    oct = cfg_sum;
                    ctl = 1'b0;
                end else begin
                    oct = 8'(cnt);
                    ctl = 1'b0;
                end
            end
            PH_DATA: begin
                oct = data_q;
                ctl = 1'b0;
            end
            default: begin
                oct = CH_COMMA;
                ctl = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

endmodule

// File: rtl/link_sync_seq.sv
module link_sync_seq
    import link_seq_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int KSEL_W = 3,
    parameter int K_STEP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_n,
    input  logic               sysref,
    input  logic [KSEL_W-1:0]  k_sel,
    input  logic [LANES*8-1:0] data_in,
    output logic [LANES*8-1:0] lane_oct,
    output logic [LANES-1:0]   lane_ctl,
    output logic [1:0]         link_state
);

    localparam int CNT_W = $clog2(K_STEP << KSEL_W);
    localparam int MF_W  = $clog2(ALIGN_MFS);

    logic [CNT_W-1:0] lmfc_cnt;
    logic [CNT_W-1:0] lmfc_last;
    logic             lmfc_wrap_next;
    phase_e           phase;
    logic [MF_W-1:0]  mf_idx;

    lmfc_counter #(
        .KSEL_W (KSEL_W),
        .K_STEP (K_STEP),
        .CNT_W  (CNT_W)
    ) u_lmfc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sysref    (sysref),
        .k_sel     (k_sel),
        .cnt       (lmfc_cnt),
        .k_last    (lmfc_last),
        .wrap_next (lmfc_wrap_next)
    );

    link_phase_fsm #(
        .MF_W (MF_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_n    (sync_n),
        .wrap_next (lmfc_wrap_next),
        .phase     (phase),
        .mf_idx    (mf_idx)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_octet_mux #(
            .LANE_ID (g),
            .LANES   (LANES),
            .CNT_W   (CNT_W),
            .MF_W    (MF_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .phase   (phase),
            .mf_idx  (mf_idx),
            .cnt     (lmfc_cnt),
            .k_last  (lmfc_last),
            .data_in (data_in[g*8 +: 8]),
            .oct     (lane_oct[g*8 +: 8]),
            .ctl     (lane_ctl[g])
        );
    end

    assign link_state = phase;

endmodule

// File: rtl/link_seq_chk.sv
module link_seq_chk #(
    parameter int LANES = 4,
    parameter int CNT_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync_n,
    input logic               sysref,
    input logic [1:0]         link_state,
    input logic [LANES*8-1:0] lane_oct,
    input logic [LANES-1:0]   lane_ctl,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   k_last
);

    a_r1_comma_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd0) |-> (lane_ctl == {LANES{1'b1}} && lane_oct == {LANES{8'hBC}}));

    a_r2_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd0 && !sync_n) |=> (link_state == 2'd0));

    a_r3_align_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd2 && $past(link_state) == 2'd1) |-> (cnt == '0));

    a_r4_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= k_last) |=> (cnt == '0));

    a_r5_sysref_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysref) |=> (cnt == '0));

    a_r8_data_no_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd3) |-> (lane_ctl == '0));

    a_r9_single_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd3 && !sync_n && $past(sync_n)) |=> (link_state == 2'd3));

    a_r10_data_from_align: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd3) |-> ($past(link_state) == 2'd2 || $past(link_state) == 2'd3));

    a_r10_lanes_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state != 2'd3) |-> ($countones(lane_ctl) == 0 || lane_ctl == {LANES{1'b1}}));

endmodule

bind link_sync_seq link_seq_chk #(
    .LANES (LANES),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_n     (sync_n),
    .sysref     (sysref),
    .link_state (link_state),
    .lane_oct   (lane_oct),
    .lane_ctl   (lane_ctl),
    .cnt        (lmfc_cnt),
    .k_last     (lmfc_last)
);

// File: tb/sim_link_sync_seq.sv
module sim_link_sync_seq;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int KSEL_W     = 3;

    logic               clk;
    logic               rst_n;
    logic               sync_n;
    logic               sysref;
    logic [KSEL_W-1:0]  k_sel;
    logic [LANES*8-1:0] data_in;
    logic [LANES*8-1:0] lane_oct;
    logic [LANES-1:0]   lane_ctl;
    logic [1:0]         link_state;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    link_sync_seq #(.LANES(LANES), .KSEL_W(KSEL_W), .K_STEP(4)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sysref(sysref),
        .k_sel(k_sel), .data_in(data_in), .lane_oct(lane_oct),
        .lane_ctl(lane_ctl), .link_state(link_state)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    // reference model state (behavioural, updated on each rising edge)
    int m_state, m_cnt, m_mf;
    bit m_low, m_sref;
    logic [LANES*8-1:0] m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_mf = 0; m_low = 0; m_sref = 0; m_data = '0;
        end else begin
            int kk, nc, ns, nmf;
            bit wrap, nlow;
            kk   = 4 * (int'(k_sel) + 1);
            nc   = (sysref && !m_sref) ? 0 : ((m_cnt >= kk - 1) ? 0 : m_cnt + 1);
            wrap = (nc == 0);
            ns   = m_state; nmf = m_mf; nlow = 0;
            if (m_state == 0) begin
                if (sync_n) ns = 1;
            end else if (m_state == 1) begin
                if (!sync_n) ns = 0;
                else if (wrap) begin ns = 2; nmf = 0; end
            end else begin
                nlow = !sync_n;
                if (!sync_n && m_low) begin ns = 0; nlow = 0; end
                else if (m_state == 2 && wrap) begin
                    if (m_mf == 3) ns = 3; else nmf = m_mf + 1;
                end
            end
            m_state = ns; m_cnt = nc; m_mf = nmf; m_low = nlow;
            m_sref = sysref; m_data = data_in;
        end
    end

    function automatic void exp_lane(input int lane, output logic [7:0] o, output logic c);
        int kk;
        kk = 4 * (int'(k_sel) + 1);
        if (m_state <= 1) begin o = 8'hBC; c = 1; end
        else if (m_state == 3) begin o = m_data[lane*8 +: 8]; c = 0; end
        else if (m_cnt == 0) begin o = 8'h1C; c = 1; end
        else if (m_cnt == kk - 1) begin o = 8'h7C; c = 1; end
        else if (m_mf == 1 && m_cnt == 1) begin o = 8'h9C; c = 1; end
        else if (m_mf == 1 && m_cnt == 2) begin o = 8'(lane); c = 0; end
        else if (m_mf == 1 && m_cnt == 3) begin o = 8'(LANES - 1); c = 0; end
        else if (m_mf == 1 && m_cnt == 4) begin o = 8'(kk - 1); c = 0; end
        else if (m_mf == 1 && m_cnt == 5) begin o = 8'(lane + LANES - 1 + kk - 1); c = 0; end
        else begin o = 8'(m_cnt); c = 0; end
    endfunction

    function automatic string tag_now();
        int kk;
        kk = 4 * (int'(k_sel) + 1);
        if (m_state == 0) return "R1";
        if (m_state == 1) return "R3";
        if (m_state == 3) return "R8";
        if (m_cnt == 0) return "R6";
        if (m_cnt == kk - 1) return "R4";
        if (m_mf == 1 && m_cnt >= 1 && m_cnt <= 5) return "R7";
        return "R6";
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        logic [LANES*8-1:0] eo;
        logic [LANES-1:0]   ec;
        string t;
        @(negedge clk);
        for (int l = 0; l < LANES; l++) begin
            logic [7:0] o; logic c;
            exp_lane(l, o, c);
            eo[l*8 +: 8] = o;
            ec[l] = c;
        end
        t = tag_now();
        chk(t, 64'(lane_oct), 64'(eo));
        chk(t, 64'(lane_ctl), 64'(ec));
        chk("R10", 64'(link_state), 64'(m_state));
        data_in = {$urandom, $urandom};
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; sync_n = 0; sysref = 0; k_sel = 3'd1; data_in = '0;
        run(3);
        chk("R1", 64'(link_state), 64'd0);
        rst_n = 1;
        // K=8, free-running boundaries
        run(10);
        sysref = 1; tick(); sysref = 0;
        run(5);
        sync_n = 1; tick();
        chk("R2", 64'(link_state), 64'd1);
        run(50);
        chk("R8", 64'(link_state), 64'd3);
        // single low in data: ignored
        sync_n = 0; tick(); sync_n = 1; tick();
        chk("R9", 64'(link_state), 64'd3);
        run(4);
        // two lows: back to commas
        sync_n = 0; tick(); tick();
        chk("R9", 64'(link_state), 64'd0);
        run(3);
        // K=4: drop inside wait
        k_sel = 3'd0;
        sync_n = 1; tick();
        sync_n = 0; tick();
        chk("R3", 64'(link_state), 64'd0);
        run(3);
        // K=32: sysref edge inside wait starts alignment
        k_sel = 3'd7;
        sysref = 1; tick(); sysref = 0;
        run(3);
        sync_n = 1; tick();
        chk("R2", 64'(link_state), 64'd1);
        sysref = 1; tick();
        chk("R5", 64'(link_state), 64'd2);
        chk("R5", 64'(lane_oct[7:0]), 64'h1C);
        run(135);
        chk("R8", 64'(link_state), 64'd3);
        // sysref level held high: no further phase reset
        run(40);
        sysref = 0;
        sync_n = 0; run(3);
        // K=4 full bring-up with precedence of start/end characters
        k_sel = 3'd0;
        sync_n = 1;
        run(30);
        chk("R8", 64'(link_state), 64'd3);
        sync_n = 0; run(4);
        chk("R9", 64'(link_state), 64'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule